// File: doc/BRIEF.md
# Two-Channel Operand Grant Arbiter

This block chooses which of two DMA channels owns the next operand transfer. Each channel presents a request line and a two-bit priority level. A smaller number means a more urgent level. The transfer sequencer reports two things to the block. The first is a busy level, held high while it is still finishing or has suspended an operand. The second is a one-cycle strobe that marks the end of an operand, whether the operand completed or was aborted.

The block drives a one-hot grant. That grant stays fixed on its channel for the whole operand. Halts, retries and bus relinquish-and-retry in the sequencer only stretch the operand, so none of them can move the grant. Requests are re-arbitrated only at an operand boundary. When the levels differ, the more urgent channel wins. When the levels tie, the channel that was not served last wins, so steady requests on both channels alternate.

The winner is held in a register. A grant therefore appears on the clock edge after the cycle in which the block is idle and sees a request. After an end strobe the grant drops for one cycle, and only then can the next arbitration take place.

Top module: `dma2_arb`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, gnt_o is 2'b00.
- R2: At a rising clock edge where gnt_o is 2'b00, busy_i is low and req_i is nonzero, gnt_o becomes nonzero after that edge. gnt_o bit 0 means channel 0 and bit 1 means channel 1.
- R3: While gnt_o is nonzero and done_i is low, gnt_o keeps its value across the edge. This holds whatever happens on req_i, prio0_i, prio1_i and busy_i, which is how halt, retry and relinquish-and-retry appear.
- R4: At an edge where gnt_o is nonzero and done_i is high, gnt_o becomes 2'b00.
- R5: When both channels request at an arbitration edge and prio0_i differs from prio1_i, the channel with the smaller numeric value is granted.
- R6: When both channels request at an arbitration edge with equal priority values, the channel granted is the one other than the channel granted most recently.
- R7: After reset, the most recently granted channel counts as channel 1, so the first tie goes to channel 0.
- R8: While gnt_o is 2'b00 and busy_i is high, no grant is issued, even with requests pending.
- R9: When only one channel requests at an arbitration edge, that channel is granted, whatever either priority value is.
- R10: gnt_o never has more than one bit set.
- R11: A done_i pulse while gnt_o is 2'b00 has no effect: with no request pending, gnt_o stays 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 2 | Request per channel, bit n is channel n |
| prio0_i | input | PRIO_W | Channel 0 priority level, smaller is more urgent |
| prio1_i | input | PRIO_W | Channel 1 priority level, smaller is more urgent |
| busy_i | input | 1 | Sequencer still holds or has suspended an operand |
| done_i | input | 1 | One-cycle strobe: operand completed or aborted |
| gnt_o | output | 2 | One-hot grant, held for the whole operand |

## Verification
The bench raises the other channel to a more urgent level while a less urgent operand is in flight, and it toggles busy_i to stand in for a halt or retry. A design without the lock would hand the grant over at that point. Back-to-back ties right after reset show whether the last-served record starts on channel 1 and whether it flips, because a wrong start or a stuck record grants the same channel twice in a row. End strobes are sent while idle, and requests are held while busy_i is high with no grant. A design that wrongly acts on either would issue a spurious grant.

// File: rtl/dma2_arb_pkg.sv
package dma2_arb_pkg;
  localparam int NCH = 2;
  typedef logic [NCH-1:0] gnt_t;
  typedef enum logic {CH0 = 1'b0, CH1 = 1'b1} ch_e;
endpackage

// File: rtl/dma2_arb_pick.sv
module dma2_arb_pick
  import dma2_arb_pkg::*;
#(
  parameter int PRIO_W = 2
) (
  input  gnt_t              req_i,
  input  logic [PRIO_W-1:0] prio0_i,
  input  logic [PRIO_W-1:0] prio1_i,
  input  ch_e               last_i,
  output ch_e               win_o,
  output logic              any_o
);
  always_comb begin
    any_o = |req_i;
    unique case (req_i)
      2'b01:   win_o = CH0;
      2'b10:   win_o = CH1;
      2'b11: begin
        if (prio0_i < prio1_i)      win_o = CH0;
        else if (prio1_i < prio0_i) win_o = CH1;
        else                        win_o = (last_i == CH1) ? CH0 : CH1;  // tie: rotate
      end
      default: win_o = CH0;
    endcase
  end
endmodule

// File: rtl/dma2_arb_lock.sv
module dma2_arb_lock
  import dma2_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  ch_e  win_i,
  input  logic done_i,
  output gnt_t gnt_o,
  output ch_e  last_o
);
  gnt_t gnt_q;
  ch_e  last_q;
  gnt_t win_oh;

  for (genvar c = 0; c < NCH; c++) begin : g_oh
    assign win_oh[c] = (int'(win_i) == c);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q  <= '0;
      last_q <= CH1;
    end else if (gnt_q != '0) begin
      if (done_i) gnt_q <= '0;   // lock released only at operand end
    end else if (start_i) begin
      gnt_q  <= win_oh;
      last_q <= win_i;
    end
  end

  assign gnt_o  = gnt_q;
  assign last_o = last_q;
endmodule

// File: rtl/dma2_arb.sv
module dma2_arb
  import dma2_arb_pkg::*;
#(
  parameter int PRIO_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        req_i,
  input  logic [PRIO_W-1:0] prio0_i,
  input  logic [PRIO_W-1:0] prio1_i,
  input  logic              busy_i,
  input  logic              done_i,
  output logic [1:0]        gnt_o
);
  ch_e  win, last;
  logic any;
  gnt_t gnt;

  dma2_arb_pick #(.PRIO_W(PRIO_W)) u_pick (
    .req_i   (req_i),
    .prio0_i (prio0_i),
    .prio1_i (prio1_i),
    .last_i  (last),
    .win_o   (win),
    .any_o   (any)
  );

  dma2_arb_lock u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (any && !busy_i),
    .win_i   (win),
    .done_i  (done_i),
    .gnt_o   (gnt),
    .last_o  (last)
  );

  assign gnt_o = gnt;
endmodule

// File: rtl/dma2_arb_chk.sv
module dma2_arb_chk #(
  parameter int PRIO_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        req_i,
  input logic [PRIO_W-1:0] prio0_i,
  input logic [PRIO_W-1:0] prio1_i,
  input logic              busy_i,
  input logic              done_i,
  input logic [1:0]        gnt_o
);
  logic seen1;  // last granted channel observed at the port

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          seen1 <= 1'b1;
    else if (gnt_o != 0)  seen1 <= gnt_o[1];
  end

  wire arb = (gnt_o == 2'b00) && !busy_i;

  // R10
  onehot_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(gnt_o));
  // R2
  grant_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb && (req_i != 0) |=> gnt_o != 2'b00);
  // R3
  grant_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != 2'b00) && !done_i |=> $stable(gnt_o));
  // R4
  grant_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != 2'b00) && done_i |=> gnt_o == 2'b00);
  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == 2'b00) && busy_i |=> gnt_o == 2'b00);
  // R11
  idle_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == 2'b00) && (req_i == 2'b00) |=> gnt_o == 2'b00);
  // R5
  prio_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb && (req_i == 2'b11) && (prio0_i != prio1_i) |=>
    gnt_o == (($past(prio0_i) < $past(prio1_i)) ? 2'b01 : 2'b10));
  // R6 R7
  tie_rotate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb && (req_i == 2'b11) && (prio0_i == prio1_i) |=>
    gnt_o == ($past(seen1) ? 2'b01 : 2'b10));
  // R9
  sole_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb && ((req_i == 2'b01) || (req_i == 2'b10)) |=> gnt_o == $past(req_i));
endmodule

bind dma2_arb dma2_arb_chk #(.PRIO_W(PRIO_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .prio0_i (prio0_i),
  .prio1_i (prio1_i),
  .busy_i  (busy_i),
  .done_i  (done_i),
  .gnt_o   (gnt_o)
);

// File: tb/dma2_arb_bench.sv
`timescale 1ns/1ps
module dma2_arb_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] req_i = 2'b00;
  logic [1:0] prio0_i = 2'd0;
  logic [1:0] prio1_i = 2'd0;
  logic       busy_i = 1'b0;
  logic       done_i = 1'b0;
  logic [1:0] gnt_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #4 clk_i = ~clk_i;  // 125 MHz

  dma2_arb #(.PRIO_W(2)) u_dma2_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .prio0_i(prio0_i),
    .prio1_i(prio1_i), .busy_i(busy_i), .done_i(done_i), .gnt_o(gnt_o)
  );

  // behavioural reference
  logic [1:0] m_gnt;
  int m_last;
  int w;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_gnt = 2'b00;
      m_last = 1;
    end else if (m_gnt != 2'b00) begin
      if (done_i) m_gnt = 2'b00;
    end else if (!busy_i && req_i != 2'b00) begin
      if (req_i == 2'b01) w = 0;
      else if (req_i == 2'b10) w = 1;
      else if (prio0_i < prio1_i) w = 0;
      else if (prio1_i < prio0_i) w = 1;
      else w = 1 - m_last;
      m_gnt = (w == 0) ? 2'b01 : 2'b10;
      m_last = w;
    end
  end

  task automatic check(input string r, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: gnt_o=%b expected %b at %0t", r, act, exp, $time);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      check(cur_req, gnt_o, m_gnt);
    end
  endtask

  task automatic finish_op();
    done_i = 1'b1;
    tick();
    done_i = 1'b0;
  endtask

  initial begin
    #20;
    check("R1", gnt_o, 2'b00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    tick();
    check("R1", gnt_o, 2'b00);

    // first tie after reset goes to ch0, then alternation
    cur_req = "R7";
    prio0_i = 2'd1; prio1_i = 2'd1; req_i = 2'b11;
    tick();
    check("R7", gnt_o, 2'b01);
    cur_req = "R3";
    prio1_i = 2'd0; busy_i = 1'b1; tick();
    busy_i = 1'b0; tick();
    busy_i = 1'b1; req_i = 2'b10; tick(2);
    check("R3", gnt_o, 2'b01);
    busy_i = 1'b0;
    cur_req = "R4";
    finish_op();
    check("R4", gnt_o, 2'b00);
    cur_req = "R6";
    prio1_i = 2'd1; req_i = 2'b11;
    tick();
    check("R6", gnt_o, 2'b10);
    finish_op();
    tick();
    check("R6", gnt_o, 2'b01);
    finish_op();
    tick();
    check("R6", gnt_o, 2'b10);
    finish_op();

    // differing priorities: more urgent always wins
    cur_req = "R5";
    prio0_i = 2'd3; prio1_i = 2'd0;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R5", gnt_o, 2'b10);
      finish_op();
    end
    prio0_i = 2'd0; prio1_i = 2'd2;
    tick();
    check("R5", gnt_o, 2'b01);
    finish_op();

    // sole requester wins despite worse level, then keeps lock
    cur_req = "R9";
    req_i = 2'b00; tick();
    prio0_i = 2'd3; prio1_i = 2'd0; req_i = 2'b01;
    tick();
    check("R9", gnt_o, 2'b01);
    cur_req = "R3";
    req_i = 2'b11; busy_i = 1'b1; tick(3);
    busy_i = 1'b0; tick(2);
    check("R3", gnt_o, 2'b01);
    cur_req = "R5";
    finish_op();
    tick();
    check("R5", gnt_o, 2'b10);
    finish_op();

    // busy with no grant blocks arbitration
    cur_req = "R8";
    busy_i = 1'b1; req_i = 2'b11;
    tick(4);
    check("R8", gnt_o, 2'b00);
    busy_i = 1'b0;
    cur_req = "R2";
    tick();
    check("R2", gnt_o, 2'b10);
    finish_op();

    // done while idle is ignored
    cur_req = "R11";
    req_i = 2'b00; tick();
    for (int k = 0; k < 3; k++) finish_op();
    check("R11", gnt_o, 2'b00);
    cur_req = "R2";
    prio0_i = 2'd2; prio1_i = 2'd2; req_i = 2'b11;
    tick();
    check("R6", gnt_o, 2'b01);
    finish_op();

    // reset mid-operand, then tie again goes to ch0
    cur_req = "R1";
    req_i = 2'b10; tick();
    rst_ni = 1'b0; #1;
    check("R1", gnt_o, 2'b00);
    @(negedge clk_i); rst_ni = 1'b1;
    cur_req = "R7";
    req_i = 2'b11;
    tick();
    check("R7", gnt_o, 2'b01);
    check("R10", gnt_o & (gnt_o - 2'b01), 2'b00);
    finish_op();
    tick(5);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run hung, gnt_o=%b expected completion", gnt_o);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule